// File: doc/BRIEF.md
# Bit-Sliced Four-Bit Integer ALU

This block is a purely combinational arithmetic and logic unit for two 4-bit two's-complement operands. A 3-bit operation code selects one of five operations: bitwise AND, bitwise OR, addition, subtraction and signed set-less-than. Alongside the 4-bit result it drives a flag that marks an all-zero result and a flag that marks signed overflow.

The datapath is four identical one-bit slices. Each slice holds a full adder and a four-way result selector. The carry ripples from bit 0 up to bit 3. The upper opcode bit does two jobs: it inverts the second operand and seeds the carry into bit 0. Subtraction is therefore a + ~b + 1 on the same adder. Set-less-than reads the sign of that difference and corrects it with the overflow term, so no separate comparator is needed. The two low opcode bits pick what each slice returns. There is no clock, no register and no stored state. The outputs settle one ripple delay after the inputs change.

Top module: `slice_alu`

## Requirements
- R1: Opcode 3'b000 drives result = opnd_a & opnd_b.
- R2: Opcode 3'b001 drives result = opnd_a | opnd_b.
- R3: Opcode 3'b010 drives result = (opnd_a + opnd_b) modulo 16.
- R4: Opcode 3'b110 drives result = (opnd_a - opnd_b) modulo 16, formed as opnd_a + ~opnd_b + 1.
- R5: Opcode 3'b111 drives result = 4'b0001 when opnd_a is less than opnd_b as signed two's-complement values, and 4'b0000 otherwise. This holds even when the difference overflows.
- R6: is_zero is 1 exactly when all four result bits are 0, for every opcode.
- R7: For opcodes 3'b010 and 3'b110, signed_ovf is 1 exactly when the signed sum or difference falls outside -8..7.
- R8: signed_ovf is 0 whenever opcode bits [1:0] are not 2'b10. This covers AND, OR and set-less-than.
- R9: The unlisted opcodes follow the same bit fields. Bit 2 inverts opnd_b and is the carry into bit 0. Bits [1:0] select AND (00), OR (01), the sum (10) or the corrected less-than bit (11). So 3'b100 gives opnd_a & ~opnd_b, 3'b101 gives opnd_a | ~opnd_b, and 3'b011 gives 1 when the signed value of opnd_a + opnd_b is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 4 | First operand, two's complement |
| opnd_b | input | 4 | Second operand, two's complement |
| opcode | input | 3 | Operation select: bit 2 inverts b and seeds the carry, bits 1:0 pick the slice output |
| result | output | 4 | Operation result |
| is_zero | output | 1 | High when result is all zeros |
| signed_ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The block holds no state, so any wrong internal value shows at the ports in the same evaluation that produced it. It never waits for a later cycle.

Some faults only appear for particular operands:
- A broken carry link between slices corrupts add and subtract only for operand pairs that generate a carry into that slice.
- A wrong overflow term changes signed_ovf, and also the set-less-than bit, but only for pairs whose signed difference leaves -8..7.

For this reason every opcode, including the three unlisted ones, is swept over all 256 operand pairs. Each pair is checked against a reference model that the bench builds from the requirements.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

    localparam int ALU_W = 4;
    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_AND = 3'b000,
        OPC_OR  = 3'b001,
        OPC_ADD = 3'b010,
        OPC_SUB = 3'b110,
        OPC_SLT = 3'b111
    } alu_opc_e;

    // What a slice returns, taken straight from opcode bits [1:0]
    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } pick_e;

    typedef struct packed {
        logic  invert_b;
        logic  carry_seed;
        pick_e pick;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_opcode(input logic [OPC_W-1:0] code);
        alu_ctrl_t c;
        c.invert_b   = code[2];
        c.carry_seed = code[2];
        c.pick       = pick_e'(code[1:0]);
        return c;
    endfunction

    function automatic logic parity3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic majority3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import slice_alu_pkg::*;
(
    input  logic  a_bit,
    input  logic  b_bit,
    input  logic  carry_in,
    input  logic  invert_b,
    input  logic  less_in,
    input  pick_e pick,
    output logic  res_bit,
    output logic  sum_bit,
    output logic  carry_out
);

    logic b_eff;

    assign b_eff     = b_bit ^ invert_b;
    assign sum_bit   = parity3(a_bit, b_eff, carry_in);
    assign carry_out = majority3(a_bit, b_eff, carry_in);

    always_comb begin
        unique case (pick)
            PICK_AND:  res_bit = a_bit & b_eff;
            PICK_OR:   res_bit = a_bit | b_eff;
            PICK_SUM:  res_bit = sum_bit;
            PICK_LESS: res_bit = less_in;
            default:   res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import slice_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0] res_vec,
    input  logic         carry_into_msb,
    input  logic         carry_out_msb,
    input  logic         sum_msb,
    input  pick_e        pick,
    output logic         zero_flag,
    output logic         ovf_flag,
    output logic         less_bit
);

    logic ovf_raw;

    // Signed overflow: the carry into the sign slice differs from the carry out of it
    assign ovf_raw   = carry_into_msb ^ carry_out_msb;
    // The sign of the difference, corrected when the difference overflows
    assign less_bit  = sum_msb ^ ovf_raw;
    assign ovf_flag  = (pick == PICK_SUM) & ovf_raw;
    assign zero_flag = ~|res_vec;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [OPC_W-1:0] opcode,
    output logic [W-1:0]     result,
    output logic             is_zero,
    output logic             signed_ovf
);

    alu_ctrl_t ctrl;
    logic      slt_bit;
    logic      msb_cin;
    logic      msb_cout;
    logic      msb_sum;

    assign ctrl = decode_opcode(opcode);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic cin;
        logic cout;
        logic sum;
        logic res;
        logic less;

        if (i == 0) begin : g_lsb
            assign cin  = ctrl.carry_seed;
            assign less = slt_bit;
        end else begin : g_upper
            assign cin  = g_bit[i-1].cout;
            assign less = 1'b0;
        end

        alu_bit_slice u_slice (
            .a_bit    (opnd_a[i]),
            .b_bit    (opnd_b[i]),
            .carry_in (cin),
            .invert_b (ctrl.invert_b),
            .less_in  (less),
            .pick     (ctrl.pick),
            .res_bit  (res),
            .sum_bit  (sum),
            .carry_out(cout)
        );

        assign result[i] = res;
    end

    assign msb_cin  = g_bit[W-1].cin;
    assign msb_cout = g_bit[W-1].cout;
    assign msb_sum  = g_bit[W-1].sum;

    alu_flag_unit #(.W(W)) u_flags (
        .res_vec       (result),
        .carry_into_msb(msb_cin),
        .carry_out_msb (msb_cout),
        .sum_msb       (msb_sum),
        .pick          (ctrl.pick),
        .zero_flag     (is_zero),
        .ovf_flag      (signed_ovf),
        .less_bit      (slt_bit)
    );

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [2:0]   opcode,
    input logic [W-1:0] result,
    input logic         is_zero,
    input logic         signed_ovf
);

    logic [W-1:0] sum_ref;
    logic [W-1:0] dif_ref;

    assign sum_ref = opnd_a + opnd_b;
    assign dif_ref = opnd_a - opnd_b;

    always_comb begin
        if (opcode == 3'b000) AST_AND_RESULT: assert (result == (opnd_a & opnd_b)); // R1
        if (opcode == 3'b001) AST_OR_RESULT: assert (result == (opnd_a | opnd_b)); // R2
        if (opcode == 3'b010) AST_ADD_RESULT: assert (result == sum_ref); // R3
        if (opcode == 3'b110) AST_SUB_RESULT: assert (result == dif_ref); // R4
        if (opcode == 3'b111) AST_SLT_UPPER_CLEAR: assert (result[W-1:1] == '0); // R5
        AST_ZERO_FLAG: assert (is_zero == (result == '0)); // R6
        if (opcode == 3'b010) AST_ADD_OVERFLOW: assert (signed_ovf == ((opnd_a[W-1] == opnd_b[W-1]) && (sum_ref[W-1] != opnd_a[W-1]))); // R7
        if (opcode[1:0] != 2'b10) AST_NO_OVERFLOW: assert (!signed_ovf); // R8
    end

endmodule

bind slice_alu slice_alu_chk #(.W(W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .opcode    (opcode),
    .result    (result),
    .is_zero   (is_zero),
    .signed_ovf(signed_ovf)
);

// File: tb/sim_slice_alu.sv
`timescale 1ns/1ps
module sim_slice_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a_drv = '0;
    logic [3:0] b_drv = '0;
    logic [2:0] op_drv = '0;
    logic [3:0] r_obs;
    logic       z_obs;
    logic       v_obs;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    typedef struct {
        logic [3:0] a;
        logic [3:0] b;
        logic [2:0] op;
        logic [3:0] r;
        logic       z;
        logic       v;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    slice_alu u0 (
        .opnd_a    (a_drv),
        .opnd_b    (b_drv),
        .opcode    (op_drv),
        .result    (r_obs),
        .is_zero   (z_obs),
        .signed_ovf(v_obs)
    );

    // Reference model built from the requirements
    function automatic exp_t model(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op);
        exp_t e;
        int sa, sb, s;
        logic [3:0] bb;
        logic [4:0] full;
        sa = $signed(a);
        sb = $signed(b);
        e.a = a; e.b = b; e.op = op; e.v = 1'b0;
        case (op)
            3'b000: begin e.r = a & b; e.tag = "R1/R6/R8"; end
            3'b001: begin e.r = a | b; e.tag = "R2/R6/R8"; end
            3'b010: begin
                s = sa + sb; e.r = a + b;
                e.v = (s > 7) || (s < -8); e.tag = "R3/R6/R7";
            end
            3'b110: begin
                s = sa - sb; e.r = a - b;
                e.v = (s > 7) || (s < -8); e.tag = "R4/R6/R7";
            end
            3'b111: begin e.r = (sa < sb) ? 4'd1 : 4'd0; e.tag = "R5/R6/R8"; end
            default: begin
                // R9: field-wise behaviour of the unlisted codes
                bb   = op[2] ? ~b : b;
                full = {1'b0, a} + {1'b0, bb} + {4'b0, op[2]};
                case (op[1:0])
                    2'b00:   e.r = a & bb;
                    2'b01:   e.r = a | bb;
                    default: begin
                        s = sa + $signed(bb) + (op[2] ? 1 : 0);
                        e.r = (s < 0) ? 4'd1 : 4'd0;
                    end
                endcase
                if (full[4]) e.tag = "R9/R6/R8"; else e.tag = "R9/R6/R8";
            end
        endcase
        e.z = (e.r == 4'd0);
        return e;
    endfunction

    task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op);
        @(posedge clk);
        #1;
        a_drv  = a;
        b_drv  = b;
        op_drv = op;
        sb_q.push_back(model(a, b, op));
    endtask

    // Monitor: outputs settle at posedge+1, sampled at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (r_obs !== e.r || z_obs !== e.z || v_obs !== e.v) begin
                errors++;
                $display("FAIL %s op=%b a=%h b=%h actual r=%h z=%b v=%b expected r=%h z=%b v=%b",
                         e.tag, e.op, e.a, e.b, r_obs, z_obs, v_obs, e.r, e.z, e.v);
            end
        end
    end

    initial begin
        // Idle state under reset: AND of zero operands, R1 and R6
        sb_q.push_back(model(4'd0, 4'd0, 3'b000));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Defined opcodes (R1..R8), then the unlisted ones (R9)
        for (int k = 0; k < 8; k++) begin
            for (int ia = 0; ia < 16; ia++) begin
                for (int ib = 0; ib < 16; ib++) begin
                    drive(4'(ia), 4'(ib), 3'(k));
                end
            end
        end
        wait (sb_q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule